// File: doc/BRIEF.md
# Four-Input Programmable Logic Cell

This block is a small programmable logic cell that realises any Boolean function of its four logic inputs. It is built from three 3-input look-up tables. The two first-level tables hold the residues of the function for the expansion input at 0 and at 1. The output table merges the two residues, and the expansion input drives its top select line. The expansion input is a configuration field, because the cheapest decomposition for a given function is not known in advance.

A shared-residue mode serves functions whose two residues are complements of each other. In that mode one residue table feeds both residue lines of the output table, one of them inverted, and the second residue table plays no part.

All configuration arrives over a one-bit serial chain while the enable is high. Once loading ends, the function output depends combinationally on the logic inputs and on nothing else.

Top module: `lutc_cluster`

## Requirements
- R1: After reset the whole configuration word is zero, so the output is 0 for every input value.
- R2: While `cfg_en` is low, `cfg_din` has no effect: the configuration and the function stay as they are.
- R3: The 27-bit configuration word is shifted in MSB first, one bit per rising edge with `cfg_en` high, and the last bit shifted lands in bit 0. The fields are: [26:25] expansion-input index, [24] shared-residue flag, [23:16] residue-0 table, [15:8] residue-1 table, [7:0] output table. In every table, bit i is the value returned for address i.
- R4: The expansion input X is `lin[idx]`, where idx is field [26:25]. X drives bit 2 of the output-table address.
- R5: Both residue tables are addressed by the three inputs other than X, taken in ascending index order, with the lowest of them on address bit 0.
- R6: With the shared flag clear, the output-table address is {X, residue-1 value, residue-0 value}. Bit 1 carries residue 1 and bit 0 carries residue 0.
- R7: With the shared flag set, address bit 1 of the output table is the inverse of the residue-0 value, and the residue-1 table contents have no effect.
- R8: The output is combinational from `lin`. It follows an input change with no clock edge between them.
- R9: For any 16-entry truth table T and any choice of X, the output equals T[lin] when three conditions hold: the output table is 8'hCA, residue 0 holds T with X=0, and residue 1 holds T with X=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside through a two-stage synchroniser |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data |
| lin | input | 4 | Logic inputs |
| f | output | 1 | Function output |

## Verification
The function output carries no register, so the bench changes `lin` just after a falling edge and samples `f` two time units later, before the next rising edge. Each configuration bit enters at the rising edge after the falling edge that drives it. The bench therefore drops `cfg_en` one falling edge after the 27th bit, and checks the new function only from then on. After reset is released, the synchroniser needs two rising edges before the chain accepts data, and the bench waits longer than that before loading.

// File: rtl/lutc_pkg.sv
package lutc_pkg;
  localparam int NUM_IN  = 4;
  localparam int SEL_W   = $clog2(NUM_IN);
  localparam int LUT_K   = NUM_IN - 1;
  localparam int TBL_W   = 2 ** LUT_K;
  localparam int CFG_W   = SEL_W + 1 + 3 * TBL_W;

  typedef struct packed {
    logic [SEL_W-1:0] xsel;
    logic             share;
    logic [TBL_W-1:0] res0;
    logic [TBL_W-1:0] res1;
    logic [TBL_W-1:0] outt;
  } cfg_t;
endpackage

// File: rtl/lutc_rst_sync.sv
module lutc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lutc_cfg_chain.sv
module lutc_cfg_chain #(
  parameter int WIDTH = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sdin,
  output logic [WIDTH-1:0] word
);
  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] word_d;

  // next state: shift toward the MSB when enabled, else hold
  always_comb begin
    if (shift_en) word_d = {word_q[WIDTH-2:0], sdin};
    else          word_d = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/lutc_lut.sv
module lutc_lut #(
  parameter int K = 3
) (
  input  logic [2**K-1:0] cells,
  input  logic [K-1:0]    addr,
  output logic            dout
);
  localparam int NODES = 2 ** (K + 1) - 1;

  // binary mux tree stored level by level; level l starts at
  // 2**(K+1) - 2**(K+1-l) and holds 2**(K-l) nodes
  logic [NODES-1:0] node;

  assign node[2**K-1:0] = cells;

  for (genvar l = 0; l < K; l++) begin : g_lvl
    localparam int BI = 2 ** (K + 1) - 2 ** (K + 1 - l);
    localparam int BO = 2 ** (K + 1) - 2 ** (K - l);
    for (genvar j = 0; j < 2 ** (K - l - 1); j++) begin : g_mux
      assign node[BO + j] = addr[l] ? node[BI + 2*j + 1] : node[BI + 2*j];
    end
  end

  assign dout = node[NODES-1];
endmodule

// File: rtl/lutc_route.sv
module lutc_route #(
  parameter int NUM_IN = 4,
  parameter int SEL_W  = $clog2(NUM_IN)
) (
  input  logic [NUM_IN-1:0] lin,
  input  logic [SEL_W-1:0]  xsel,
  output logic              xval,
  output logic [NUM_IN-2:0] raddr
);
  assign xval = lin[xsel];

  // residue address bit k skips the expansion input
  for (genvar k = 0; k < NUM_IN - 1; k++) begin : g_pick
    assign raddr[k] = (xsel > SEL_W'(k)) ? lin[k] : lin[k+1];
  end
endmodule

// File: rtl/lutc_cluster.sv
module lutc_cluster
  import lutc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_din,
  input  logic [NUM_IN-1:0] lin,
  output logic              f
);
  logic             core_rst_n;
  logic [CFG_W-1:0] cfg_q;
  cfg_t             cfg;
  logic             xval;
  logic [LUT_K-1:0] raddr;
  logic             r0v;
  logic             r1v;
  logic             hi_res;

  lutc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  lutc_cfg_chain #(.WIDTH(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .shift_en (cfg_en),
    .sdin     (cfg_din),
    .word     (cfg_q)
  );

  assign cfg = cfg_t'(cfg_q);

  lutc_route #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_route (
    .lin   (lin),
    .xsel  (cfg.xsel),
    .xval  (xval),
    .raddr (raddr)
  );

  lutc_lut #(.K(LUT_K)) u_res0 (
    .cells (cfg.res0),
    .addr  (raddr),
    .dout  (r0v)
  );

  lutc_lut #(.K(LUT_K)) u_res1 (
    .cells (cfg.res1),
    .addr  (raddr),
    .dout  (r1v)
  );

  assign hi_res = cfg.share ? ~r0v : r1v;

  lutc_lut #(.K(LUT_K)) u_out (
    .cells (cfg.outt),
    .addr  ({xval, hi_res, r0v}),
    .dout  (f)
  );
endmodule

// File: rtl/lutc_cluster_chk.sv
module lutc_cluster_chk
  import lutc_pkg::*;
(
  input logic              clk,
  input logic              core_rst_n,
  input logic              cfg_en,
  input logic              cfg_din,
  input logic [NUM_IN-1:0] lin,
  input logic              f,
  input logic [CFG_W-1:0]  cfg_q
);
  logic [SEL_W-1:0] xs;
  assign xs = cfg_q[CFG_W-1 -: SEL_W];

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cfg_en |=> $stable(cfg_q));

  // R3
  shift_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    cfg_en |=> (cfg_q == {$past(cfg_q[CFG_W-2:0]), $past(cfg_din)}));

  // R8
  comb_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!cfg_en && !$past(cfg_en) && $stable(lin)) |-> $stable(f));

  // R7
  share_flip_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!cfg_en && !$past(cfg_en) && cfg_q[CFG_W-SEL_W-1]
     && (cfg_q[TBL_W-1:0] == 8'hCA)
     && (lin == ($past(lin) ^ (NUM_IN'(1) << xs)))) |-> (f != $past(f)));
endmodule

bind lutc_cluster lutc_cluster_chk chk_i (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .cfg_en     (cfg_en),
  .cfg_din    (cfg_din),
  .lin        (lin),
  .f          (f),
  .cfg_q      (cfg_q)
);

// File: tb/lutc_cluster_test.sv
module lutc_cluster_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_en;
  logic       cfg_din;
  logic [3:0] lin;
  logic       f;
  int         checks = 0;
  int         errors = 0;

  lutc_cluster uut (
    .clk (clk), .rst_n (rst_n), .cfg_en (cfg_en),
    .cfg_din (cfg_din), .lin (lin), .f (f)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [26:0] mkw(input logic [1:0] xs, input logic sh,
      input logic [7:0] t0, input logic [7:0] t1, input logic [7:0] to);
    return {xs, sh, t0, t1, to};
  endfunction

  // spec model: address = three non-X inputs ascending; out addr {X,c,b}
  function automatic logic model(input logic [26:0] w, input logic [3:0] v);
    logic [1:0] xs = w[26:25];
    logic [2:0] a  = '0;
    int k = 0;
    logic b, c;
    for (int p = 0; p < 4; p++) begin
      if (p != int'(xs)) begin a[k] = v[p]; k++; end
    end
    b = w[16 + int'(a)];
    c = w[24] ? ~b : w[8 + int'(a)];
    return w[int'({v[xs], c, b})];
  endfunction

  // inputs vector with X at position xs and residue address a elsewhere
  function automatic logic [3:0] place(input logic [1:0] xs, input logic xv,
                                       input logic [2:0] a);
    logic [3:0] v = '0;
    int k = 0;
    for (int p = 0; p < 4; p++) begin
      if (p == int'(xs)) v[p] = xv;
      else begin v[p] = a[k]; k++; end
    end
    return v;
  endfunction

  task automatic load(input logic [26:0] w);
    for (int i = 26; i >= 0; i--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = w[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic sweep(input string tag, input logic [26:0] w);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      lin = v[3:0];
      #2;
      checks++;
      if (f !== model(w, v[3:0])) begin
        errors++;
        $display("FAIL %s lin=%h actual=%b expected=%b", tag, v[3:0], f,
                 model(w, v[3:0]));
      end
    end
  endtask

  task automatic truth(input logic [1:0] xs, input logic [15:0] tt);
    logic [7:0] t0, t1;
    for (int a = 0; a < 8; a++) begin
      t0[a] = tt[place(xs, 1'b0, a[2:0])];
      t1[a] = tt[place(xs, 1'b1, a[2:0])];
    end
    load(mkw(xs, 1'b0, t0, t1, 8'hCA));
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      lin = v[3:0];
      #2;
      checks++;
      if (f !== tt[v]) begin
        errors++;
        $display("FAIL R9 tt=%h x=%0d lin=%h actual=%b expected=%b",
                 tt, xs, v[3:0], f, tt[v]);
      end
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [26:0] w;
    logic [15:0] tts [5];
    rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; lin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: zero configuration after reset
    sweep("R1", '0);

    for (int x = 0; x < 4; x++) begin
      // R4: output table passes address bit 2 (X)
      w = mkw(x[1:0], 1'b0, 8'h00, 8'h00, 8'hF0);
      load(w); sweep("R4", w);
      // R5: residue-0 returns lowest, then highest non-X input
      w = mkw(x[1:0], 1'b0, 8'hAA, 8'h00, 8'hAA);
      load(w); sweep("R5", w);
      w = mkw(x[1:0], 1'b0, 8'hF0, 8'h00, 8'hAA);
      load(w); sweep("R5", w);
      // R6: output table passes residue-1 line
      w = mkw(x[1:0], 1'b0, 8'h00, 8'h69, 8'hCC);
      load(w); sweep("R6", w);
      // R3: distinct tables in every field
      w = mkw(x[1:0], 1'b0, 8'h1E, 8'hB4, 8'h6B);
      load(w); sweep("R3", w);
      // R7: shared mode, residue-1 table ignored (two contents)
      w = mkw(x[1:0], 1'b1, 8'h17, 8'hFF, 8'hCA);
      load(w); sweep("R7", w);
      w = mkw(x[1:0], 1'b1, 8'h17, 8'h00, 8'hCA);
      load(w); sweep("R7", w);
    end

    // R2: toggling serial data with enable low changes nothing
    w = mkw(2'd2, 1'b0, 8'h5C, 8'hA3, 8'hD2);
    load(w);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cfg_din = i[0];
    end
    sweep("R2", w);

    // R8: output follows lin between clock edges
    sweep("R8", w);

    // R9: arbitrary functions through decomposition
    tts[0] = 16'h6996; tts[1] = 16'hBEEF; tts[2] = 16'h8001;
    tts[3] = 16'h1234; tts[4] = 16'hE8E8;
    for (int x = 0; x < 4; x++)
      for (int t = 0; t < 5; t++)
        truth(x[1:0], tts[t]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule